// File: doc/BRIEF.md
# Least-Recently-Used Page Frame Tracker

This block keeps track of how recently each of a fixed number of page frames has been touched, and names the frame that has gone unused the longest as the next one to evict. Every frame owns one row of a square bit matrix. A touch of frame k does two things. It fills row k with ones. It then empties column k. Once every frame has been touched, the row with the smallest unsigned value belongs to the frame touched longest ago.

A memory management controller drives one touch strobe with a frame number on each cycle that reuses a frame. When it needs a frame to replace, it reads the registered victim number while the valid flag is high. Page tables, fault handling and frame loading are handled elsewhere.

Top module: `lru_frame_tracker`

## Requirements
- R1: While `rst_n` is low on a clock edge, every matrix bit is cleared to 0 and `victim_valid` goes low. The first valid victim after reset is frame 0, because all rows are equal.
- R2: A touch (`acc_valid` high with `acc_frame` = k, k below NUM_FRAMES) writes 1 to every bit of row k on that edge, apart from the bit that R3 clears.
- R3: On the same edge the same touch writes 0 to bit k of every row, so row k ends up as all ones except its own bit k.
- R4: The victim is the frame whose row has the smallest unsigned value. Row bit 0 is the least significant bit. After every frame has been touched, this is the frame whose latest touch is the oldest.
- R5: When several rows share the smallest value, the lowest frame number is chosen. As a result, frames never touched since reset are offered first, lowest number first.
- R6: `victim_frame` and `victim_valid` are registered. `victim_valid` is low in the cycle after an edge that carried a touch. It is high in the cycle after an edge with reset released and no touch, and `victim_frame` then names the victim of the current matrix.
- R7: An edge with `acc_valid` low leaves the matrix unchanged, so the victim stays the same across idle cycles.
- R8: Touching the same frame several times in a row gives the same matrix as touching it once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| acc_valid | input | 1 | Touch strobe for the frame on `acc_frame` |
| acc_frame | input | IDX_W | Number of the frame being touched |
| victim_frame | output | IDX_W | Registered number of the least recently used frame |
| victim_valid | output | 1 | High when `victim_frame` reflects the current matrix |

## Verification
Assertions check on every cycle that the touched row holds all ones except its own bit after a touch. They also check that the touched column is clear, that an idle edge changes no bit, and that the matrix is zero after reset. At the output they check that a valid victim row is no larger than any other row and strictly smaller than every row of a lower-numbered frame, and that the valid flag follows the touch strobe with one cycle of delay. Whether the smallest row really marks the oldest touch, across long mixed orderings, repeated touches and resets in mid-stream, can only be shown by the bench scenarios, which compare against a model of touch times on every clock.

// File: rtl/lru_track_pkg.sv
`timescale 1ns/1ps
// Package: lru_track_pkg
// Shared sizing constants and helpers for the frame recency tracker.
// Assumes frame counts between 2 and MAX_FRAMES.
package lru_track_pkg;

    // Upper bound on the frame count; keeps the matrix at 4096 bits or fewer.
    localparam int MAX_FRAMES = 64;

    // Width of a frame number for a given frame count (at least 1 bit).
    function automatic int idx_bits(input int n);
        return (n <= 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/lru_recency_matrix.sv
`timescale 1ns/1ps
// Module: lru_recency_matrix
// Holds the N-by-N recency matrix. A touch of frame k fills row k with ones
// and empties column k in the same edge; the column clear wins on bit (k,k).
// Assumes touch_idx is already range-checked by the caller.
module lru_recency_matrix #(
    parameter int NUM_FRAMES = 8,
    parameter int IDX_W      = 3,
    localparam int CELLS     = NUM_FRAMES * NUM_FRAMES
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 touch,
    input  logic [IDX_W-1:0]     touch_idx,
    output logic [CELLS-1:0]     rows_flat
);

    logic [NUM_FRAMES-1:0] mat_q [NUM_FRAMES];
    logic [NUM_FRAMES-1:0] mat_d [NUM_FRAMES];
    logic [NUM_FRAMES-1:0] col_bits [NUM_FRAMES];
    logic                  was_reset_q;

    // Next-state per cell: column clear first, then row set, else hold.
    for (genvar r = 0; r < NUM_FRAMES; r++) begin : g_row
        for (genvar c = 0; c < NUM_FRAMES; c++) begin : g_col
            logic col_hit;
            logic row_hit;
            assign col_hit = touch && (touch_idx == IDX_W'(c));
            assign row_hit = touch && (touch_idx == IDX_W'(r));
            assign mat_d[r][c] = col_hit ? 1'b0 :
                                 row_hit ? 1'b1 : mat_q[r][c];
            assign col_bits[c][r] = mat_q[r][c];
        end
        assign rows_flat[r*NUM_FRAMES +: NUM_FRAMES] = mat_q[r];
    end

    // Matrix register with synchronous active-low clear.
    always_ff @(posedge clk) begin
        for (int r = 0; r < NUM_FRAMES; r++) begin
            if (!rst_n) mat_q[r] <= '0;
            else        mat_q[r] <= mat_d[r];
        end
    end

    // Remembers that the previous edge was a reset edge (checking only).
    always_ff @(posedge clk) begin
        was_reset_q <= ~rst_n;
    end

    // R1: after a reset edge the whole matrix is zero.
    p_reset_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
        was_reset_q |-> (rows_flat == '0));

    // R7: an edge without a touch leaves every bit as it was.
    p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(touch)) |-> (rows_flat == $past(rows_flat)));

    for (genvar k = 0; k < NUM_FRAMES; k++) begin : g_chk
        // R2: after a touch of k, row k is all ones except its own bit.
        p_row_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(touch && (touch_idx == IDX_W'(k))))
            |-> (mat_q[k] == ~(NUM_FRAMES'(1) << k)));
        // R3: after a touch of k, column k is empty.
        p_col_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(touch && (touch_idx == IDX_W'(k))))
            |-> (col_bits[k] == '0));
    end

endmodule

// File: rtl/lru_min_row_search.sv
`timescale 1ns/1ps
// Module: lru_min_row_search
// Combinational search for the row with the smallest unsigned value.
// A linear chain of compare stages; a later row replaces the running best
// only when strictly smaller, so ties keep the lowest frame number.
// Assumes row bit 0 is the least significant bit.
module lru_min_row_search #(
    parameter int NUM_FRAMES = 8,
    parameter int IDX_W      = 3,
    localparam int CELLS     = NUM_FRAMES * NUM_FRAMES
) (
    input  logic [CELLS-1:0]  rows_flat,
    output logic [IDX_W-1:0]  min_idx
);

    logic [NUM_FRAMES-1:0] best_val [NUM_FRAMES];
    logic [IDX_W-1:0]      best_idx [NUM_FRAMES];

    // Stage 0 seeds the chain with frame 0.
    assign best_val[0] = rows_flat[0 +: NUM_FRAMES];
    assign best_idx[0] = '0;

    // Each later stage keeps the running best unless its row is strictly smaller.
    for (genvar i = 1; i < NUM_FRAMES; i++) begin : g_stage
        logic [NUM_FRAMES-1:0] cand;
        logic                  take;
        assign cand = rows_flat[i*NUM_FRAMES +: NUM_FRAMES];
        assign take = cand < best_val[i-1];
        assign best_val[i] = take ? cand : best_val[i-1];
        assign best_idx[i] = take ? IDX_W'(i) : best_idx[i-1];
    end

    assign min_idx = best_idx[NUM_FRAMES-1];

endmodule

// File: rtl/lru_frame_tracker.sv
`timescale 1ns/1ps
// Module: lru_frame_tracker
// Top of the least-recently-used frame tracker. Range-checks the touch,
// updates the recency matrix, searches for the smallest row and registers
// the victim. The victim flag drops for one cycle after each touch, since the
// registered victim was taken from the matrix before that touch.
// Assumes 2 <= NUM_FRAMES <= MAX_FRAMES; touches of frame numbers at or
// above NUM_FRAMES are dropped.
module lru_frame_tracker
    import lru_track_pkg::*;
#(
    parameter int NUM_FRAMES = 8,
    localparam int IDX_W     = idx_bits(NUM_FRAMES),
    localparam int CELLS     = NUM_FRAMES * NUM_FRAMES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic [IDX_W-1:0]  acc_frame,
    output logic [IDX_W-1:0]  victim_frame,
    output logic              victim_valid
);

    localparam logic [IDX_W:0] FRAMES_EXT = (IDX_W+1)'(NUM_FRAMES);

    // Elaboration guard on the frame count.
    if (NUM_FRAMES < 2 || NUM_FRAMES > MAX_FRAMES) begin : g_bad_size
        $error("lru_frame_tracker: NUM_FRAMES out of range");
    end

    logic              acc_hit;
    logic [CELLS-1:0]  rows_flat;
    logic [IDX_W-1:0]  min_idx;
    logic [IDX_W-1:0]  victim_q;
    logic              valid_q;

    // Accept only touches that name an existing frame.
    assign acc_hit = acc_valid && ({1'b0, acc_frame} < FRAMES_EXT);

    lru_recency_matrix #(
        .NUM_FRAMES (NUM_FRAMES),
        .IDX_W      (IDX_W)
    ) u_matrix (
        .clk       (clk),
        .rst_n     (rst_n),
        .touch     (acc_hit),
        .touch_idx (acc_frame),
        .rows_flat (rows_flat)
    );

    lru_min_row_search #(
        .NUM_FRAMES (NUM_FRAMES),
        .IDX_W      (IDX_W)
    ) u_search (
        .rows_flat (rows_flat),
        .min_idx   (min_idx)
    );

    // Victim register: captures the search result of the pre-edge matrix.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            victim_q <= '0;
            valid_q  <= 1'b0;
        end else begin
            victim_q <= min_idx;
            valid_q  <= ~acc_hit;
        end
    end

    assign victim_frame = victim_q;
    assign victim_valid = valid_q;

    // Row of the reported victim, for the output checks below.
    logic [NUM_FRAMES-1:0] vic_row;
    assign vic_row = rows_flat[int'(victim_frame)*NUM_FRAMES +: NUM_FRAMES];

    // R6: a touch drops the valid flag on the next cycle.
    p_valid_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        acc_hit |=> !victim_valid);

    // R6: an idle edge raises the valid flag on the next cycle.
    p_valid_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_hit |=> victim_valid);

    for (genvar i = 0; i < NUM_FRAMES; i++) begin : g_out_chk
        logic [NUM_FRAMES-1:0] row_i;
        assign row_i = rows_flat[i*NUM_FRAMES +: NUM_FRAMES];
        // R4: a valid victim row is no larger than any row.
        p_victim_min_r4: assert property (@(posedge clk) disable iff (!rst_n)
            victim_valid |-> (vic_row <= row_i));
        // R5: every lower-numbered frame has a strictly larger row.
        p_tie_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (victim_valid && (victim_frame > IDX_W'(i))) |-> (row_i > vic_row));
    end

endmodule

// File: tb/sim_lru_frame_tracker.sv
`timescale 1ns/1ps
// Bench: reference model of touch times, compared with the outputs every clock.
module sim_lru_frame_tracker;

    localparam int N  = 8;
    localparam int IW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          acc_valid = 1'b0;
    logic [IW-1:0] acc_frame = '0;
    logic [IW-1:0] victim_frame;
    logic          victim_valid;

    lru_frame_tracker #(.NUM_FRAMES(N)) u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .acc_valid    (acc_valid),
        .acc_frame    (acc_frame),
        .victim_frame (victim_frame),
        .victim_valid (victim_valid)
    );

    always #10 clk = ~clk;   // 50 MHz

    int    stamp [N];
    int    tick = 0;
    bit    exp_valid = 1'b0;
    int    exp_victim = 0;
    bit    checking = 1'b0;
    string cur_req = "R1";
    int    n_checks = 0;
    int    n_fail = 0;

    // Oldest frame: never-touched frames first (lowest number), else oldest stamp.
    function automatic int ref_victim();
        int best = 0;
        for (int i = 0; i < N; i++) if (stamp[i] < 0) return i;
        for (int i = 1; i < N; i++) if (stamp[i] < stamp[best]) best = i;
        return best;
    endfunction

    // Model update on each rising edge, mirroring the requirements.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) stamp[i] = -1;
            exp_valid = 1'b0;
        end else begin
            exp_victim = ref_victim();
            exp_valid  = !acc_valid;
            if (acc_valid) stamp[acc_frame] = tick;
        end
        tick++;
    end

    // Compare on the falling edge, away from the active edge.
    always @(negedge clk) begin
        if (checking) begin
            n_checks++;
            if (victim_valid !== exp_valid) begin
                n_fail++;
                $display("FAIL %s R6 victim_valid actual=%0b expected=%0b t=%0t",
                         cur_req, victim_valid, exp_valid, $time);
            end
            if (exp_valid) begin
                n_checks++;
                if (victim_frame !== IW'(exp_victim)) begin
                    n_fail++;
                    $display("FAIL %s victim_frame actual=%0d expected=%0d t=%0t",
                             cur_req, victim_frame, exp_victim, $time);
                end
            end
        end
    end

    task automatic touch(input int f);
        @(posedge clk); #5;
        acc_valid = 1'b1;
        acc_frame = IW'(f);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #5;
            acc_valid = 1'b0;
        end
    endtask

    task automatic do_reset(input int n);
        @(posedge clk); #5;
        rst_n = 1'b0;
        acc_valid = 1'b0;
        repeat (n) @(posedge clk);
        #5 rst_n = 1'b1;
    endtask

    task automatic scenarios();
        logic [15:0] lfsr = 16'hACE1;
        // R1: reset state, then the first valid victim is frame 0.
        repeat (3) @(posedge clk);
        #5 checking = 1'b1;
        cur_req = "R1";
        do_reset(2);
        idle(3);
        // R5: untouched frames offered lowest first; R2 touched frame leaves.
        cur_req = "R5";
        touch(3); idle(2);
        touch(0); idle(2);
        cur_req = "R2";
        for (int f = 1; f < N; f++) begin touch(f); idle(1); end
        idle(2);
        // R4: back-to-back touches in reverse order, oldest is frame 7.
        cur_req = "R4";
        for (int f = N - 1; f >= 0; f--) touch(f);
        idle(3);
        // R8: repeated touches of one frame.
        cur_req = "R8";
        touch(7); touch(2); touch(2); touch(2); touch(2);
        idle(3);
        // R7: idle stretch keeps the victim.
        cur_req = "R7";
        idle(6);
        // R3: mixed pseudo-random order with gaps.
        cur_req = "R3";
        for (int i = 0; i < 400; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            if (lfsr[3]) idle(1);
            touch(int'(lfsr[2:0]));
        end
        idle(2);
        // R1: reset mid-stream, then partial refill.
        cur_req = "R1";
        touch(5);
        do_reset(1);
        idle(2);
        cur_req = "R5";
        touch(0); touch(1); idle(2);
        touch(2); touch(4); idle(3);
    endtask

    initial begin
        fork
            scenarios();
            begin
                repeat (100000) @(posedge clk);
                n_fail++;
                n_checks++;
                $display("FAIL watchdog all actual=timeout expected=completion");
            end
        join_any
        disable fork;
        @(negedge clk);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule